// File: doc/BRIEF.md
# Ramp-Down Shutdown Sequencer

This block sequences the power stage of a multiphase regulator through five states: inactive, soft-start, regulating, ramp-down and hold-off. While the stage is switching, the commanded pulse width follows the value the control loop supplies. A stop request or a fault does not cut the pulses off. Instead, the width is lowered by a programmable step on every switching-cycle tick until it reaches zero. Only then are the stage outputs released to high impedance.

After the ramp, the sequencer stays in a hold-off state for a fixed number of switching ticks before it may become inactive again. This limits how often the block can restart on its own when a fault clears as soon as the output is off. A mode input makes fault-caused shutdowns sticky. In that mode, a restart needs the enable to be dropped and raised again, or a reset. How soft-start shapes its own ramp, and how faults are detected, are both outside this block. Soft-start ends when the `ss_done_i` strobe arrives.

Top module: `ramp_shutdown_seq`

## Requirements
- R1: While `rst_ni` is low, and right after it, the state is inactive, `width_o` is 0 and `tri_o` is 1. The reset acts without waiting for a clock.
- R2: In the inactive state, the next clock enters soft-start when all of these hold: `en_i` is high, `vid_i` is not all ones, `ot_flt_i` and `ov_flt_i` are low, and no fault is latched. Otherwise the state stays inactive.
- R3: Soft-start moves to regulating on a clock where `ss_done_i` is high. In both soft-start and regulating, `tri_o` is 0 and `width_o` equals the `duty_i` value sampled at the previous clock.
- R4: In soft-start or regulating, any of these causes enters ramp-down on the next clock, with `width_o` held at its last value: `en_i` low, `vid_i` all ones, `ot_flt_i` high or `ov_flt_i` high.
- R5: In ramp-down, each clock with `tick_i` high lowers `width_o` by `rate_i`, saturating at 0. Clocks without a tick leave the width unchanged. `tri_o` stays 0.
- R6: A clock in ramp-down with `width_o` at 0 enters hold-off. In hold-off, `tri_o` is 1 and `width_o` is 0.
- R7: Hold-off returns to inactive on the clock of its `HOLD_TICKS`-th tick. Faults, VID changes and enable changes during ramp-down or hold-off neither restart the ramp nor reset the hold-off count.
- R8: Ramp-down is entered only from soft-start or regulating. A stop cause seen while inactive keeps the block inactive.
- R9: With `latch_mode_i` high, a fault that causes a shutdown from soft-start or regulating is latched. The latch blocks any restart until a clock samples `en_i` low, or until a reset. With `latch_mode_i` low, the block restarts by itself once the hold-off ends and the start conditions hold.
- R10: `state_o` encodes inactive=0, soft-start=1, regulating=2, ramp-down=3, hold-off=4. No other value occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per switching cycle |
| en_i | input | 1 | Output enable level |
| vid_i | input | VID_W | Voltage code; all ones requests shutdown |
| ot_flt_i | input | 1 | Over-temperature fault |
| ov_flt_i | input | 1 | Output over-voltage fault |
| latch_mode_i | input | 1 | 1: faults latch, 0: auto-restart |
| rate_i | input | PW_W | Width decrement per tick during ramp-down |
| duty_i | input | PW_W | Width from the control loop |
| ss_done_i | input | 1 | Soft-start complete |
| width_o | output | PW_W | Commanded pulse width |
| tri_o | output | 1 | 1 = power stage outputs high impedance |
| state_o | output | 3 | Sequencer state |

## Verification
The bench aims at the last ramp step, where the remaining width is smaller than the rate. A design without saturation would wrap to a large width and never reach hold-off. It pulses faults and toggles enable during hold-off, so that a design that restarts the timer or re-enters ramp-down shows a hold-off that lasts too long. It sends each of the four stop causes from regulating and applies a stop cause while inactive. A latched fault must survive a steady high enable and clear only after a low enable. A design that clears it early restarts too soon, and one that never clears it stays inactive for good.

// File: rtl/ramp_shdn_pkg.sv
package ramp_shdn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SOFT = 3'd1,
    ST_RUN  = 3'd2,
    ST_RAMP = 3'd3,
    ST_HOLD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/shdn_cause.sv
module shdn_cause #(
  parameter int VID_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             ot_flt_i,
  input  logic             ov_flt_i,
  input  logic             latch_mode_i,
  input  logic             switching_i,
  output logic             stop_o,
  output logic             start_ok_o,
  output logic             latched_o
);
  logic vid_off;
  logic fault;
  logic latch_q;

  assign vid_off = &vid_i;
  assign fault   = ot_flt_i | ov_flt_i;
  assign stop_o  = ~en_i | vid_off | fault;
  assign start_ok_o = en_i & ~vid_off & ~fault & ~latch_q;
  assign latched_o  = latch_q;

  // enable low clears; only a fault that ends switching sets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   latch_q <= 1'b0;
    else if (!en_i)                                latch_q <= 1'b0;
    else if (switching_i && fault && latch_mode_i) latch_q <= 1'b1;
  end
endmodule

// File: rtl/width_ramp.sv
module width_ramp #(
  parameter int PW_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic            dec_i,
  input  logic [PW_W-1:0] duty_i,
  input  logic [PW_W-1:0] rate_i,
  output logic [PW_W-1:0] width_o,
  output logic            zero_o
);
  logic [PW_W-1:0] width_q;
  logic [PW_W-1:0] stepped;

  assign stepped = (width_q > rate_i) ? (width_q - rate_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     width_q <= '0;
    else if (clr_i)  width_q <= '0;
    else if (load_i) width_q <= duty_i;
    else if (dec_i)  width_q <= stepped;
  end

  assign width_o = width_q;
  assign zero_o  = (width_q == '0);
endmodule

// File: rtl/holdoff_timer.sv
module holdoff_timer #(
  parameter int HOLD_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i & tick_i & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ramp_shutdown_seq.sv
module ramp_shutdown_seq
  import ramp_shdn_pkg::*;
#(
  parameter int PW_W       = 8,
  parameter int VID_W      = 6,
  parameter int HOLD_TICKS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [VID_W-1:0] vid_i,
  input  logic             ot_flt_i,
  input  logic             ov_flt_i,
  input  logic             latch_mode_i,
  input  logic [PW_W-1:0]  rate_i,
  input  logic [PW_W-1:0]  duty_i,
  input  logic             ss_done_i,
  output logic [PW_W-1:0]  width_o,
  output logic             tri_o,
  output logic [2:0]       state_o
);
  seq_state_e st_q, st_d;
  logic switching, stop, start_ok, fault_latched;
  logic width_zero, hold_done;
  logic ld, dec, clr;

  assign switching = (st_q == ST_SOFT) || (st_q == ST_RUN);

  shdn_cause #(.VID_W(VID_W)) u_cause (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .vid_i(vid_i),
    .ot_flt_i(ot_flt_i), .ov_flt_i(ov_flt_i), .latch_mode_i(latch_mode_i),
    .switching_i(switching), .stop_o(stop), .start_ok_o(start_ok),
    .latched_o(fault_latched)
  );

  assign ld  = switching && !stop;
  assign dec = (st_q == ST_RAMP) && tick_i && !width_zero;
  assign clr = (st_q == ST_IDLE) || (st_q == ST_HOLD);

  width_ramp #(.PW_W(PW_W)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .load_i(ld), .dec_i(dec),
    .duty_i(duty_i), .rate_i(rate_i), .width_o(width_o), .zero_o(width_zero)
  );

  holdoff_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(st_q == ST_HOLD),
    .tick_i(tick_i), .done_o(hold_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_ok) st_d = ST_SOFT;
      ST_SOFT: if (stop) st_d = ST_RAMP;
               else if (ss_done_i) st_d = ST_RUN;
      ST_RUN:  if (stop) st_d = ST_RAMP;
      ST_RAMP: if (width_zero) st_d = ST_HOLD;
      ST_HOLD: if (hold_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign tri_o   = clr;
  assign state_o = st_q;
endmodule

// File: rtl/ramp_shutdown_seq_chk.sv
module ramp_shutdown_seq_chk
  import ramp_shdn_pkg::*;
#(
  parameter int PW_W  = 8,
  parameter int VID_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             en_i,
  input logic [VID_W-1:0] vid_i,
  input logic             ot_flt_i,
  input logic             ov_flt_i,
  input logic [PW_W-1:0]  width_o,
  input logic             tri_o,
  input logic [2:0]       state_o,
  input logic             fault_latched
);
  p_idle_safe_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_IDLE |-> tri_o && width_o == '0);

  p_stop_enters_ramp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RUN && (!en_i || (&vid_i) || ot_flt_i || ov_flt_i)) |=> state_o == ST_RAMP);

  p_ramp_nonincr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_RAMP |=> width_o <= $past(width_o));

  p_ramp_no_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_RAMP && !tick_i) |=> $stable(width_o));

  p_ramp_drives_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_RAMP |-> !tri_o);

  p_hold_safe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_HOLD |-> tri_o && width_o == '0);

  p_hold_exit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == ST_HOLD |=> (state_o == ST_HOLD || state_o == ST_IDLE));

  p_ramp_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE || state_o == ST_HOLD) |=> state_o != ST_RAMP);

  p_latch_blocks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_latched && state_o == ST_IDLE) |=> state_o == ST_IDLE);

  p_state_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4);
endmodule

bind ramp_shutdown_seq ramp_shutdown_seq_chk #(.PW_W(PW_W), .VID_W(VID_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i), .vid_i(vid_i),
  .ot_flt_i(ot_flt_i), .ov_flt_i(ov_flt_i), .width_o(width_o), .tri_o(tri_o),
  .state_o(state_o), .fault_latched(fault_latched)
);

// File: tb/ramp_shutdown_seq_test.sv
module ramp_shutdown_seq_test;
  localparam int PW_W = 8;
  localparam int VID_W = 6;
  localparam int HOLD_TICKS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, en = 1'b0, ot = 1'b0, ov = 1'b0, lmode = 1'b0, ss_done = 1'b0;
  logic [VID_W-1:0] vid = '0;
  logic [PW_W-1:0] rate = '0, duty = '0;
  logic [PW_W-1:0] width;
  logic tri_s;
  logic [2:0] state;

  int checks = 0, errs = 0;
  bit finished = 1'b0;
  bit auto_chk = 1'b0;

  always #5 clk = ~clk;

  ramp_shutdown_seq #(.PW_W(PW_W), .VID_W(VID_W), .HOLD_TICKS(HOLD_TICKS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en), .vid_i(vid),
    .ot_flt_i(ot), .ov_flt_i(ov), .latch_mode_i(lmode), .rate_i(rate),
    .duty_i(duty), .ss_done_i(ss_done), .width_o(width), .tri_o(tri_s),
    .state_o(state)
  );

  // reference model built from the requirements
  int m_st;
  logic [PW_W-1:0] m_w;
  int m_cnt;
  bit m_lat;

  always @(posedge clk or negedge rst_n) begin : model
    bit flt, stp;
    int old_st;
    if (!rst_n) begin
      m_st = 0; m_w = '0; m_cnt = 0; m_lat = 1'b0;
    end else begin
      flt = ot | ov;
      stp = !en || (&vid) || flt;
      old_st = m_st;
      case (m_st)
        0: begin m_w = '0; if (en && !(&vid) && !flt && !m_lat) m_st = 1; end
        1: if (stp) m_st = 3; else begin m_w = duty; if (ss_done) m_st = 2; end
        2: if (stp) m_st = 3; else m_w = duty;
        3: if (m_w == '0) begin m_st = 4; m_cnt = 0; end
           else if (tick) m_w = (m_w > rate) ? m_w - rate : '0;
        default: begin
          m_w = '0;
          if (tick) begin
            if (m_cnt == HOLD_TICKS - 1) m_st = 0; else m_cnt++;
          end
        end
      endcase
      if (!en) m_lat = 1'b0;
      else if ((old_st == 1 || old_st == 2) && flt && lmode) m_lat = 1'b1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s);
    case (s)
      0: return "R2";
      1, 2: return "R3";
      3: return "R5";
      default: return "R7";
    endcase
  endfunction

  always @(negedge clk) begin
    if (auto_chk && rst_n) begin
      chk({tag_of(m_st), " R10 state"}, int'(state), m_st);
      chk({tag_of(m_st), " width"}, int'(width), int'(m_w));
      chk({(m_st == 0 || m_st == 4) ? "R6" : "R5", " tri"}, int'(tri_s),
          (m_st == 0 || m_st == 4) ? 1 : 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input int s);
    for (int i = 0; i < 200; i++) begin
      if (int'(state) == s) return;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    cyc(3);
    chk("R1 state", int'(state), 0);
    chk("R1 width", int'(width), 0);
    chk("R1 tri", int'(tri_s), 1);
    rst_n = 1'b1;
    auto_chk = 1'b1;
    en = 1'b1; duty = 8'd100;
    cyc(1); chk("R2 start", int'(state), 1);
    cyc(1); chk("R3 width follows", int'(width), 100);
    ss_done = 1'b1;
    cyc(1); chk("R3 to run", int'(state), 2);
    ot = 1'b1; rate = 8'd30;
    cyc(1); chk("R4 ot ramp", int'(state), 3); chk("R4 held width", int'(width), 100);
    ot = 1'b0; tick = 1'b1;
    cyc(3); chk("R5 step", int'(width), 10);
    cyc(1); chk("R5 saturate", int'(width), 0);
    cyc(1); chk("R6 hold", int'(state), 4); chk("R6 tri", int'(tri_s), 1);
    ot = 1'b1; en = 1'b0;
    cyc(2); ot = 1'b0; en = 1'b1;
    cyc(5); chk("R7 still hold", int'(state), 4);
    cyc(1); chk("R7 idle", int'(state), 0);
    cyc(1); chk("R9 auto restart", int'(state), 1);
    rate = 8'hFF;
    for (int c = 0; c < 4; c++) begin
      wait_state(2);
      case (c)
        0: en = 1'b0;
        1: vid = '1;
        2: ot = 1'b1;
        default: ov = 1'b1;
      endcase
      cyc(1); chk("R4 cause", int'(state), 3);
      en = 1'b1; vid = '0; ot = 1'b0; ov = 1'b0;
      wait_state(0);
    end
    vid = '1;
    wait_state(0);
    cyc(3); chk("R8 idle stays", int'(state), 0);
    vid = '0; lmode = 1'b1;
    wait_state(2);
    ov = 1'b1; cyc(1); ov = 1'b0;
    wait_state(0);
    cyc(4); chk("R9 latched", int'(state), 0);
    en = 1'b0; cyc(1); en = 1'b1;
    cyc(1); chk("R9 cleared", int'(state), 1);
    lmode = 1'b0;
    // constrained random phase
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      tick = ($urandom % 3) == 0;
      en = ($urandom % 40) != 0;
      vid = (($urandom % 60) == 0) ? '1 : VID_W'($urandom % ((1 << VID_W) - 1));
      ot = ($urandom % 70) == 0;
      ov = ($urandom % 80) == 0;
      duty = PW_W'($urandom);
      ss_done = ($urandom % 8) == 0;
      if (($urandom % 50) == 0) rate = PW_W'(($urandom % 64) + 1);
      if ((i % 500) == 0) lmode = $urandom % 2;
      rst_n = ($urandom % 1500) != 0;
    end
    rst_n = 1'b1;
    cyc(2);
    finish_run();
  end
endmodule